// File: doc/BRIEF.md
# Idle-Headroom Frequency Boost Controller

This controller sits beside the clock and voltage control of a two-core processor. It decides which frequency code and voltage ID the running core receives. Software asks for the top performance state. If the other core is then in a deep idle state (level 3 or deeper), the running core gets a pre-programmed boosted operating point, which lies above the guaranteed maximum. In every other case a top-state request is clipped to the guaranteed point, and a lower request passes through unchanged. A disable input forces the guaranteed point whatever the other conditions are.

Moves into and out of the boosted point are sequenced around two done handshakes that stand in for the regulator and the PLL. On entry the voltage is raised first, and the frequency is raised only once the regulator reports done. On exit the frequency is lowered first, and the voltage follows once the PLL reports done. The idle core may wake briefly. A window counter lets the boost survive a wakeup that is shorter than the window. After any exit, a programmable holdoff counter must run out before the boost can be granted again.

Top module: `idle_boost_ctrl`

## Requirements
- R1: While reset is held, freq_o, vid_o and boost_active are 0. On the first clock edge after release, the outputs show the request point.
- R2: Entry begins when all of these hold: req_top is 1, one core reports idle level 0, the other reports level 3 or deeper, boost_dis is 0, and the holdoff has expired.
- R3: Entry order. First vid_o becomes boost_vid while freq_o stays at guar_freq. After vr_done, freq_o becomes boost_freq. After pll_done, boost_active becomes 1.
- R4: If req_top is 1 and no core pair qualifies (both cores active, or the other core's level is below 3), the outputs are guar_freq and guar_vid, with boost_active at 0.
- R5: If req_top is 0, the outputs follow req_freq and req_vid, one edge after they change.
- R6: While boost_dis is 1 the boost is never granted. If boost_dis is seen high while boosted, the exit starts on that edge.
- R7: The boost is kept, and boost_active stays 1, if the idle core returns to level 3 or deeper before the wake window expires.
- R8: If the idle core stays below level 3 for wake_window consecutive edges, boost_active falls on the last of those edges.
- R9: Exit order. First freq_o becomes guar_freq while vid_o stays at boost_vid. After pll_done, vid_o becomes guar_vid. After vr_done, the controller is idle.
- R10: When the exit completes (vr_done sampled), the holdoff counter loads reentry_holdoff. The next entry can begin only on the edge after the counter reaches zero.
- R11: boost_active is 1 only while freq_o is boost_freq and vid_o is boost_vid.
- R12: If req_top is seen low while boosted, the exit starts on that edge. After the exit the outputs return to the request point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core0_cst | input | CST_W | Core 0 idle level, 0 = running |
| core1_cst | input | CST_W | Core 1 idle level, 0 = running |
| req_top | input | 1 | Software requests the top performance state |
| req_freq | input | FREQ_W | Frequency code for a non-top request |
| req_vid | input | VID_W | Voltage ID for a non-top request |
| boost_dis | input | 1 | Forces the guaranteed point |
| boost_freq | input | FREQ_W | Programmed boosted frequency code |
| boost_vid | input | VID_W | Programmed boosted voltage ID |
| guar_freq | input | FREQ_W | Guaranteed maximum frequency code |
| guar_vid | input | VID_W | Guaranteed maximum voltage ID |
| wake_window | input | CNT_W | Edges of tolerated dual-core activity |
| reentry_holdoff | input | CNT_W | Holdoff edges after an exit |
| vr_done | input | 1 | Regulator finished the last voltage change |
| pll_done | input | 1 | PLL finished the last frequency change |
| freq_o | output | FREQ_W | Granted frequency code |
| vid_o | output | VID_W | Granted voltage ID |
| boost_active | output | 1 | Boosted frequency applied |

## Verification
The scoreboard records every change of the output triple and compares it with the expected order. It therefore catches a design that raises the frequency before the voltage, lowers the voltage before the frequency, or raises boost_active while a ramp is still in progress.

The wake window is probed one edge either side of its end. A counter off by one would hold the boost one edge too long or drop it one edge early. A short wakeup must leave boost_active untouched; a design that drops the boost as soon as the core wakes would fail here.

After an exit caused by a one-cycle disable pulse, the re-entry delay is counted exactly. This exposes a holdoff that is never loaded, or one that counts from the wrong event. The bench also checks that a shallow idle level, or the disable input, produces the clipped point and never a boost.

// File: rtl/idle_boost_ctrl.sv
module idle_boost_ctrl #(
  parameter int FREQ_W   = 8,
  parameter int VID_W    = 6,
  parameter int CST_W    = 3,
  parameter int DEEP_LVL = 3,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CST_W-1:0]  core0_cst,
  input  logic [CST_W-1:0]  core1_cst,
  input  logic              req_top,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [VID_W-1:0]  req_vid,
  input  logic              boost_dis,
  input  logic [FREQ_W-1:0] boost_freq,
  input  logic [VID_W-1:0]  boost_vid,
  input  logic [FREQ_W-1:0] guar_freq,
  input  logic [VID_W-1:0]  guar_vid,
  input  logic [CNT_W-1:0]  wake_window,
  input  logic [CNT_W-1:0]  reentry_holdoff,
  input  logic              vr_done,
  input  logic              pll_done,
  output logic [FREQ_W-1:0] freq_o,
  output logic [VID_W-1:0]  vid_o,
  output logic              boost_active
);

  localparam logic [CST_W-1:0] DEEP = CST_W'(DEEP_LVL);

  typedef enum logic [2:0] {
    S_IDLE, S_VUP, S_FUP, S_BOOST, S_WAKE, S_FDN, S_VDN
  } st_t;

  st_t st_q, st_d;
  logic partner_q, partner_d;
  logic [CNT_W-1:0] win_q, hold_q;

  wire c0_run  = (core0_cst == '0);
  wire c1_run  = (core1_cst == '0);
  wire c0_deep = (core0_cst >= DEEP);
  wire c1_deep = (core1_cst >= DEEP);
  wire pair1   = c0_run && c1_deep;
  wire pair0   = c1_run && c0_deep;
  wire want    = req_top && !boost_dis;
  wire partner_deep = partner_q ? c1_deep : c0_deep;
  wire win_end = ({1'b0, win_q} + (CNT_W+1)'(1)) >= {1'b0, wake_window};

  always_comb begin
    st_d = st_q;
    partner_d = partner_q;
    unique case (st_q)
      S_IDLE:
        if (want && (pair0 || pair1) && hold_q == '0) begin
          st_d = S_VUP;
          partner_d = pair1;
        end
      S_VUP:
        if (vr_done) st_d = (want && partner_deep) ? S_FUP : S_VDN;
      S_FUP:
        if (pll_done) st_d = want ? S_BOOST : S_FDN;
      S_BOOST:
        if (!want) st_d = S_FDN;
        else if (!partner_deep) st_d = S_WAKE;
      S_WAKE:
        if (!want) st_d = S_FDN;
        else if (partner_deep) st_d = S_BOOST;
        else if (win_end) st_d = S_FDN;
      S_FDN:
        if (pll_done) st_d = S_VDN;
      S_VDN:
        if (vr_done) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  logic [FREQ_W-1:0] freq_d;
  logic [VID_W-1:0]  vid_d;

  always_comb begin
    unique case (st_d)
      S_IDLE: begin
        freq_d = req_top ? guar_freq : req_freq;
        vid_d  = req_top ? guar_vid  : req_vid;
      end
      S_VUP:                  begin freq_d = guar_freq;  vid_d = boost_vid; end
      S_FUP, S_BOOST, S_WAKE: begin freq_d = boost_freq; vid_d = boost_vid; end
      S_FDN:                  begin freq_d = guar_freq;  vid_d = boost_vid; end
      default:                begin freq_d = guar_freq;  vid_d = guar_vid;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      partner_q    <= 1'b0;
      win_q        <= '0;
      hold_q       <= '0;
      freq_o       <= '0;
      vid_o        <= '0;
      boost_active <= 1'b0;
    end else begin
      st_q         <= st_d;
      partner_q    <= partner_d;
      freq_o       <= freq_d;
      vid_o        <= vid_d;
      boost_active <= (st_d == S_BOOST) || (st_d == S_WAKE);
      if (st_q == S_BOOST)     win_q <= CNT_W'(1);
      else if (st_q == S_WAKE) win_q <= win_q + CNT_W'(1);
      if (st_q == S_VDN && vr_done)            hold_q <= reentry_holdoff;
      else if (st_q == S_IDLE && hold_q != '0) hold_q <= hold_q - CNT_W'(1);
    end
  end

endmodule

module idle_boost_ctrl_chk #(
  parameter int FREQ_W = 8,
  parameter int VID_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_top,
  input logic              boost_dis,
  input logic [FREQ_W-1:0] boost_freq,
  input logic [VID_W-1:0]  boost_vid,
  input logic [FREQ_W-1:0] freq_o,
  input logic [VID_W-1:0]  vid_o,
  input logic              boost_active
);

  assert_active_point_R11: assert property (@(posedge clk) disable iff (!rst_n)
    boost_active |-> (freq_o == boost_freq && vid_o == boost_vid));

  assert_entry_ramped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_active) |-> ($past(freq_o) == boost_freq && $past(vid_o) == boost_vid));

  assert_exit_volt_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boost_active) |-> vid_o == boost_vid);

  assert_no_grant_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_active) |-> $past(!boost_dis && req_top));

  assert_disable_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_active && boost_dis) |=> !boost_active);

  assert_request_drop_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_active && !req_top) |=> !boost_active);

endmodule

bind idle_boost_ctrl idle_boost_ctrl_chk #(.FREQ_W(FREQ_W), .VID_W(VID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_top(req_top), .boost_dis(boost_dis),
  .boost_freq(boost_freq), .boost_vid(boost_vid),
  .freq_o(freq_o), .vid_o(vid_o), .boost_active(boost_active)
);

// File: tb/idle_boost_ctrl_tb.sv
module idle_boost_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int WIN = 8;
  localparam int HOLD = 5;
  localparam logic [7:0] GF = 8'd100, BF = 8'd120, RF = 8'd60, RF2 = 8'd70;
  localparam logic [5:0] GV = 6'd20,  BV = 6'd26,  RV = 6'd14, RV2 = 6'd16;

  typedef struct packed { logic [7:0] f; logic [5:0] v; logic a; } pt_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cs0 = '0, cs1 = '0;
  logic req_top = 1'b0, dis = 1'b0;
  logic [7:0] req_f = RF;
  logic [5:0] req_v = RV;
  logic vr_done = 1'b0, pll_done = 1'b0;
  logic [7:0] freq_o;
  logic [5:0] vid_o;
  logic boost_active;

  idle_boost_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .core0_cst(cs0), .core1_cst(cs1),
    .req_top(req_top), .req_freq(req_f), .req_vid(req_v), .boost_dis(dis),
    .boost_freq(BF), .boost_vid(BV), .guar_freq(GF), .guar_vid(GV),
    .wake_window(16'(WIN)), .reentry_holdoff(16'(HOLD)),
    .vr_done(vr_done), .pll_done(pll_done),
    .freq_o(freq_o), .vid_o(vid_o), .boost_active(boost_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit mon_en = 1'b0, finished = 1'b0;
  pt_t exp_q[$];
  string tag_q[$];
  pt_t last;

  task automatic chk(input bit ok, input string req, input string act, input string expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] f, input logic [5:0] v, input logic a, input string tag);
    exp_q.push_back('{f: f, v: v, a: a});
    tag_q.push_back(tag);
  endtask

  function automatic string ps(input pt_t p);
    return $sformatf("f=%0d v=%0d a=%0d", p.f, p.v, p.a);
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (finished) return;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // regulator and PLL models: a done pulse LAT negedges after each output change
  int vr_cnt = 0, pll_cnt = 0;
  logic [5:0] vid_seen = '0;
  logic [7:0] freq_seen = '0;
  always @(negedge clk) begin
    vr_done  = (vr_cnt == 1);
    pll_done = (pll_cnt == 1);
    if (vr_cnt > 0) vr_cnt--;
    if (pll_cnt > 0) pll_cnt--;
    if (vid_o !== vid_seen) begin vid_seen = vid_o; vr_cnt = LAT; end
    if (freq_o !== freq_seen) begin freq_seen = freq_o; pll_cnt = LAT; end
  end

  // monitor: every change of the output triple is popped against the queue
  always @(negedge clk) begin
    pt_t cur;
    cur = '{f: freq_o, v: vid_o, a: boost_active};
    if (mon_en && cur != last) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "sequence", ps(cur), "no change");
      end else begin
        pt_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cur == e, t, ps(cur), ps(e));
      end
      last = cur;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      chk(1'b0, "watchdog", "hung", "finish");
      finish_run();
    end
  end

  initial begin
    wait_n(4);
    chk(freq_o == 0 && vid_o == 0 && boost_active == 0, "R1 in reset",
        $sformatf("%0d/%0d/%0d", freq_o, vid_o, boost_active), "0/0/0");
    rst_n = 1'b1;
    @(negedge clk);
    chk(freq_o == RF && vid_o == RV && !boost_active, "R1 after release",
        $sformatf("%0d/%0d", freq_o, vid_o), $sformatf("%0d/%0d", RF, RV));
    last = '{f: freq_o, v: vid_o, a: boost_active};
    mon_en = 1'b1;
    wait_n(8);

    // R5: non-top request passes through
    push(RF2, RV2, 0, "R5");
    req_f = RF2; req_v = RV2;
    wait_n(10);
    chk(freq_o == RF2 && vid_o == RV2, "R5", $sformatf("%0d", freq_o), $sformatf("%0d", RF2));

    // R4: top request with both cores running is clipped
    push(GF, GV, 0, "R4");
    req_top = 1'b1;
    wait_n(10);
    chk(freq_o == GF && vid_o == GV && !boost_active, "R4 both running",
        $sformatf("%0d", freq_o), $sformatf("%0d", GF));
    cs1 = 3'd2;
    wait_n(10);
    chk(freq_o == GF && !boost_active, "R4 shallow idle", $sformatf("%0d", freq_o), $sformatf("%0d", GF));

    // R6: disabled, deep partner, no grant
    dis = 1'b1; cs1 = 3'd4;
    wait_n(20);
    chk(!boost_active && vid_o == GV, "R6 disabled", $sformatf("%0d", vid_o), $sformatf("%0d", GV));

    // R2, R3, R11: entry
    push(GF, BV, 0, "R3 volt first");
    push(BF, BV, 0, "R3 freq second");
    push(BF, BV, 1, "R11 active last");
    dis = 1'b0;
    wait_n(30);
    chk(boost_active && freq_o == BF, "R2 entry", $sformatf("%0d", freq_o), $sformatf("%0d", BF));

    // R7: short wake
    cs1 = 3'd0;
    wait_n(3);
    cs1 = 3'd3;
    wait_n(5);
    chk(boost_active == 1, "R7 short wake", $sformatf("%0d", boost_active), "1");

    // R8, R9: long wake
    push(GF, BV, 0, "R9 freq first");
    push(GF, GV, 0, "R9 volt second");
    cs1 = 3'd0;
    wait_n(WIN - 1);
    chk(boost_active == 1, "R8 before window end", $sformatf("%0d", boost_active), "1");
    wait_n(1);
    chk(boost_active == 0, "R8 at window end", $sformatf("%0d", boost_active), "0");
    wait_n(20);

    // R2: re-entry with partner deep again
    push(GF, BV, 0, "R3");
    push(BF, BV, 0, "R3");
    push(BF, BV, 1, "R11");
    cs1 = 3'd5;
    wait_n(30);
    chk(boost_active == 1, "R2 re-entry", $sformatf("%0d", boost_active), "1");

    // R10: holdoff after a one-cycle disable pulse
    push(GF, BV, 0, "R6 pulse exit");
    push(GF, GV, 0, "R9");
    push(GF, BV, 0, "R10 re-entry");
    push(BF, BV, 0, "R3");
    push(BF, BV, 1, "R11");
    dis = 1'b1;
    @(negedge clk);
    dis = 1'b0;
    begin
      int k;
      int guard;
      guard = 0;
      while (vid_o != GV && guard < 100) begin @(negedge clk); guard++; end
      k = 0;
      while (vid_o != BV && k < 100) begin @(negedge clk); k++; end
      chk(k == HOLD + LAT + 2, "R10 holdoff", $sformatf("%0d", k), $sformatf("%0d", HOLD + LAT + 2));
    end
    wait_n(20);

    // R6: disable held while boosted
    push(GF, BV, 0, "R6 exit");
    push(GF, GV, 0, "R9");
    dis = 1'b1;
    wait_n(30);
    chk(!boost_active && vid_o == GV, "R6 held", $sformatf("%0d", vid_o), $sformatf("%0d", GV));
    push(GF, BV, 0, "R3");
    push(BF, BV, 0, "R3");
    push(BF, BV, 1, "R11");
    dis = 1'b0;
    wait_n(30);

    // R12: request dropped while boosted
    push(GF, BV, 0, "R12 exit");
    push(GF, GV, 0, "R9");
    push(RF2, RV2, 0, "R12 request point");
    req_top = 1'b0;
    wait_n(30);
    chk(freq_o == RF2 && vid_o == RV2 && !boost_active, "R12 final",
        $sformatf("%0d/%0d", freq_o, vid_o), $sformatf("%0d/%0d", RF2, RV2));

    wait_n(5);
    chk(exp_q.size() == 0, "sequence drained", $sformatf("%0d left", exp_q.size()), "0 left");
    finish_run();
  end
endmodule